// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises one word per frame onto a single TX line. A frame is a low start bit, a data field of 7, 8 or 9 bits sent least significant bit first, and one high stop bit. Each bit lasts from one baud tick to the next. When parity is switched on, the top bit of the data field carries a computed parity bit in place of user data, so the frame length stays the same. A caller writes a word into a one-entry holding register. The block moves the word into its shifter as soon as the line is free. Two flags report the state: one says the holding register is empty, the other says the last frame has fully left.

The frame format (word-length code, parity enable, parity sense) can only be changed while the global enable is low. A low pulse on the transmit enable during a frame queues one idle preamble, which is a frame-length stretch of high line sent after the current frame. Dropping the global enable silences the line, throws away everything in flight and resets the flags. The format settings are kept.

Top module: `uart_frame_tx`

## Requirements
- R1: The word-length code selects the data field width: 00 selects 8 bits, 01 selects 9 bits, 10 selects 7 bits, and the reserved 11 is treated as 8 bits. The frame is one start bit (0), then the field LSB first, then one stop bit (1). The line changes only on baud ticks while a frame is in flight.
- R2: When parity is on, the field's top bit (bit N-1 for an N-bit field) is replaced by a parity bit over bits 0 to N-2. With parity sense 0 the field holds an even number of ones. With parity sense 1 it holds an odd number.
- R3: The format inputs are captured only while the global enable is 0. Changes made while it is 1 have no effect on any frame.
- R4: While the global enable is 0, the line is high from the next clock on. The frame in flight, the pending word and any queued preamble are discarded. tx_empty reads 1 and tx_done reads 0. Writes are ignored.
- R5: A write strobe while enabled stores the word and clears tx_empty on the next clock. tx_empty sets again on the clock at which the word moves into the shifter.
- R6: A stored word starts its frame (start bit on the line) on the clock after the line is free with the transmit enable at 1. While the transmit enable is 0, no new frame starts and the line stays high.
- R7: tx_done sets on the clock that ends a stop bit if no word is pending and no preamble is queued. It clears on a write, on the start of any frame, and on global disable.
- R8: A rising transmit enable while a frame is in flight queues one preamble. The preamble is high for the full frame length of the current format and is sent before any pending word.
- R9: After reset the line is high, tx_empty is 1, tx_done is 0, and the format is 8 bits with no parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable; 0 stops and clears the block |
| tx_en | input | 1 | Transmit enable; a low pulse during a frame queues a preamble |
| wlen_code | input | 2 | Word-length code |
| par_en | input | 1 | Parity insertion enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | 9 | Word to send (upper bits unused in shorter formats) |
| txd | output | 1 | Serial output line, idle high |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Last frame fully sent |

## Verification
Words are sent in each of the four length codes, with parity off, even and odd. Data values of all ones, all zeros and alternating bits are used, so that a wrong field width, a wrong bit order or a wrong parity sense each produce a different line pattern. Back-to-back writes separate holding-register timing from shifter timing. A preamble pulse with a word queued behind it checks the ordering and the high stretch. A format change made while enabled, a mid-frame disable and writes made while disabled each show an input that must leave the line and flags unchanged.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA = 9;
  localparam int FRAME_W  = MAX_DATA + 2;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
  } fmt_t;

  // field width for a word-length code; 11 falls back to 8
  function automatic int data_bits(logic [1:0] code);
    case (code)
      2'b01:   return 9;
      2'b10:   return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(logic [1:0] code);
    return CNT_W'(data_bits(code) + 2);
  endfunction

  // start bit at index 0, field LSB first, stop and fill bits high
  function automatic logic [FRAME_W-1:0] build_frame(logic [MAX_DATA-1:0] d, fmt_t f);
    int n;
    logic [MAX_DATA-1:0] fld;
    logic p;
    logic [FRAME_W-1:0] fr;
    n   = data_bits(f.wlen);
    fld = d;
    p   = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < n - 1) p = p ^ d[i];
    if (f.par_en) fld[n-1] = p ^ f.par_odd;
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < n) fr[i+1] = fld[i];
    return fr;
  endfunction
endpackage

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       glb_en,
  input  logic [1:0] wlen_in,
  input  logic       par_en_in,
  input  logic       par_odd_in,
  output fmt_t       fmt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fmt <= '0;
    else if (!glb_en) fmt <= '{wlen: wlen_in, par_en: par_en_in, par_odd: par_odd_in};
  end

  p_fmt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    glb_en |=> $stable(fmt));
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FW = uart_tx_pkg::FRAME_W,
  parameter int CW = uart_tx_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] len_in,
  input  logic          tick,
  output logic          busy,
  output logic          line,
  output logic          end_evt
);
  logic [FW-1:0] sh;
  logic [CW-1:0] left;

  assign end_evt = busy && tick && (left == CW'(1));
  assign line    = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; left <= '0; busy <= 1'b0;
    end else if (clr) begin
      sh <= '1; left <= '0; busy <= 1'b0;
    end else if (load) begin
      sh <= frame_in; left <= len_in; busy <= 1'b1;
    end else if (busy && tick) begin
      sh   <= {1'b1, sh[FW-1:1]};
      left <= left - CW'(1);
      if (left == CW'(1)) busy <= 1'b0;
    end
  end

  p_line_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !clr) |=> $stable(line));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                glb_en,
  input  logic                tx_en,
  input  logic [1:0]          wlen_code,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                baud_tick,
  input  logic                wr_stb,
  input  logic [MAX_DATA-1:0] wr_data,
  output logic                txd,
  output logic                tx_empty,
  output logic                tx_done
);
  fmt_t                fmt;
  logic                busy, end_evt;
  logic                hold_full, pre_pend, tx_en_q, done_q;
  logic [MAX_DATA-1:0] hold_data;
  logic                wr_ok, pre_go, data_go, load_go, pre_req;
  logic [FRAME_W-1:0]  frame_sel;

  uart_tx_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .wlen_in(wlen_code), .par_en_in(par_en), .par_odd_in(par_odd), .fmt(fmt)
  );

  // internal events, named for the assertions
  assign wr_ok   = glb_en && wr_stb;
  assign pre_go  = glb_en && tx_en && !busy && pre_pend;
  assign data_go = glb_en && tx_en && !busy && !pre_pend && hold_full;
  assign load_go = pre_go || data_go;
  assign pre_req = glb_en && busy && tx_en && !tx_en_q;

  assign frame_sel = pre_go ? '1 : build_frame(hold_data, fmt);

  uart_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clr(!glb_en), .load(load_go),
    .frame_in(frame_sel), .len_in(frame_len(fmt.wlen)), .tick(baud_tick),
    .busy(busy), .line(txd), .end_evt(end_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_en_q <= 1'b0;
    else        tx_en_q <= tx_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0; hold_data <= '0; pre_pend <= 1'b0; done_q <= 1'b0;
    end else if (!glb_en) begin
      hold_full <= 1'b0; pre_pend <= 1'b0; done_q <= 1'b0;
    end else begin
      if (data_go) hold_full <= 1'b0;
      if (wr_ok) begin
        hold_full <= 1'b1;
        hold_data <= wr_data;
      end
      if (pre_go)  pre_pend <= 1'b0;
      if (pre_req) pre_pend <= 1'b1;
      if (load_go || wr_ok)                       done_q <= 1'b0;
      else if (end_evt && !hold_full && !pre_pend) done_q <= 1'b1;
    end
  end

  assign tx_empty = !hold_full;
  assign tx_done  = done_q;

  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> txd);
  p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !tx_empty);
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |=> !txd);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !busy);
  p_pre_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |=> txd);
endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
  logic       clk = 0, rst_n = 0, glb_en = 0, tx_en = 0;
  logic [1:0] wlen_code = 0;
  logic       par_en = 0, par_odd = 0, baud_tick = 0, wr_stb = 0;
  logic [8:0] wr_data = 0;
  logic       txd, tx_empty, tx_done;
  int         n_cmp = 0, n_bad = 0, cyc = 0, bcnt = 0;

  uart_frame_tx dut_i (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #2;
    bcnt = (bcnt == 3) ? 0 : bcnt + 1;
    baud_tick = (bcnt == 0);
  end

  // reference model: queue of line levels
  bit         mq[$];
  bit         m_hv, m_pre, m_done, m_tprev;
  int         m_hd;
  int         m_w, m_p, m_o;

  function automatic int nbits(int w);
    if (w == 1) return 9;
    if (w == 2) return 7;
    return 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_hv = 0; m_pre = 0; m_done = 0; m_tprev = 0;
      m_w = 0; m_p = 0; m_o = 0; m_hd = 0;
    end else if (!glb_en) begin
      mq.delete(); m_hv = 0; m_pre = 0; m_done = 0;
      m_w = wlen_code; m_p = par_en; m_o = par_odd;
      m_tprev = tx_en;
    end else begin
      bit busy0, ended, spre, sdat;
      int n, ones;
      busy0 = mq.size() > 0;
      ended = 0;
      if (busy0 && baud_tick) begin
        void'(mq.pop_front());
        ended = (mq.size() == 0);
      end
      spre = !busy0 && tx_en && m_pre;
      sdat = !busy0 && tx_en && !m_pre && m_hv;
      n = nbits(m_w);
      if (spre) for (int i = 0; i < n + 2; i++) mq.push_back(1'b1);
      if (sdat) begin
        ones = 0;
        for (int i = 0; i < n - 1; i++) ones += (m_hd >> i) & 1;
        mq.push_back(1'b0);
        for (int i = 0; i < n; i++)
          if (m_p != 0 && i == n - 1) mq.push_back(bit'((ones % 2) ^ m_o));
          else mq.push_back(bit'((m_hd >> i) & 1));
        mq.push_back(1'b1);
      end
      if (spre || sdat || wr_stb) m_done = 0;
      else if (ended && !m_hv && !m_pre) m_done = 1;
      if (sdat) m_hv = 0;
      if (wr_stb) begin m_hv = 1; m_hd = wr_data; end
      if (spre) m_pre = 0;
      if (busy0 && tx_en && !m_tprev) m_pre = 1;
      m_tprev = tx_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit et;
      et = (mq.size() > 0) ? mq[0] : 1'b1;
      n_cmp += 3;
      if (txd !== et) begin
        n_bad++;
        $display("FAIL R1 R2 R3 R8 txd cyc %0d actual %b expected %b", cyc, txd, et);
      end
      if (tx_empty !== !m_hv) begin
        n_bad++;
        $display("FAIL R5 tx_empty cyc %0d actual %b expected %b", cyc, tx_empty, !m_hv);
      end
      if (tx_done !== m_done) begin
        n_bad++;
        $display("FAIL R7 tx_done cyc %0d actual %b expected %b", cyc, tx_done, m_done);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #2; endtask

  task automatic put(input int d);
    step(); wr_stb = 1; wr_data = 9'(d);
    step(); wr_stb = 0;
  endtask

  task automatic setfmt(input int w, input int p, input int o);
    step(); glb_en = 0; wlen_code = 2'(w); par_en = p[0]; par_odd = o[0];
    step(); step(); glb_en = 1;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (mq.size() == 0 && !m_hv && !m_pre) break;
      step();
    end
    repeat (3) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R9 idle line", txd, 1);
    chk(tx_empty == 1, "R9 empty", tx_empty, 1);
    chk(tx_done == 0, "R9 done", tx_done, 0);
    glb_en = 1; tx_en = 1;
    // R1 each length code, patterns that expose width and order
    for (int w = 0; w < 4; w++) begin
      setfmt(w, 0, 0);
      put(9'h1A5); drain();
      put(9'h0FF); drain();
      put(9'h100); drain();
    end
    @(negedge clk);
    chk(tx_done == 1, "R7 done after last frame", tx_done, 1);
    // R2 parity both senses in 7/8/9-bit fields
    for (int w = 0; w < 3; w++)
      for (int o = 0; o < 2; o++) begin
        setfmt(w, 1, o);
        put(9'h0B3); drain();
        put(9'h155); put(9'h0AA); drain();
      end
    // R3 format change while enabled is ignored
    setfmt(0, 0, 0);
    step(); wlen_code = 2'b01; par_en = 1; par_odd = 1;
    put(9'h1FF); drain();
    put(9'h000); drain();
    // R5 back-to-back writes
    put(9'h011); put(9'h122); put(9'h033); drain();
    // R6 transmitter disabled holds data
    step(); tx_en = 0;
    put(9'h05A);
    for (int i = 0; i < 30; i++) begin
      step(); @(negedge clk);
      if (txd != 1 || tx_empty != 0) chk(0, "R6 held while tx off", txd, 1);
    end
    chk(tx_empty == 0, "R6 still pending", tx_empty, 0);
    step(); tx_en = 1; drain();
    // R8 preamble pulse with a word queued behind it
    put(9'h0C3);
    repeat (6) step();
    tx_en = 0; step(); tx_en = 1;
    put(9'h03C); drain();
    // R4 disable mid-frame
    put(9'h000); repeat (8) step();
    glb_en = 0; step(); @(negedge clk);
    chk(txd == 1, "R4 line high", txd, 1);
    chk(tx_empty == 1, "R4 empty", tx_empty, 1);
    chk(tx_done == 0, "R4 done cleared", tx_done, 0);
    put(9'h000);
    @(negedge clk);
    chk(tx_empty == 1, "R4 write ignored", tx_empty, 1);
    step(); glb_en = 1;
    for (int i = 0; i < 40; i++) begin
      step(); @(negedge clk);
      if (txd != 1) chk(0, "R4 no frame after ignored write", txd, 1);
    end
    put(9'h155); drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule